// File: doc/BRIEF.md
# Polarity-Aware GPIO Controller

This block is a 32-pin general-purpose I/O port behind a plain 32-bit word-addressed register bus. Software picks each pin's direction. It drives output levels through a data register, which also has write-one-to-set and write-one-to-clear aliases so that single bits can be changed without a read-modify-write. Software reads the pin levels after a two-flop synchronizer.

Pins 0 to 15 each own a dedicated interrupt line toward a downstream interrupt controller. That controller only understands active-high levels and rising edges. For this reason the output-data bit of an interrupt pin also acts as its polarity select, and it inverts the synchronized pin before it reaches the line. A per-pin mode bit instead turns the line into a detector that fires on both edges and ignores polarity.

Register selection is held in an enumerated decode (`SEL_DIR`, `SEL_IN`, `SEL_OUT`, `SEL_SET`, `SEL_CLR`, `SEL_MODE`, `SEL_NONE`). Each per-pin interrupt line has two states: level-follow (mode bit 0) and both-edge (mode bit 1). Writing the mode bit moves a line between them, and the new state takes effect on the next clock edge.

Top module: `gpio_pol_irq`

## Requirements
- R1: After reset, the direction, output-data and interrupt-mode registers are zero, no pin output enable is asserted, `reg_rdata` is zero and every interrupt line is low.
- R2: The direction register sits at byte offset 0x00 and is read/write. Bit n = 1 asserts `pins_oe[n]`. Bit n = 0 makes pin n an input.
- R3: The output-data register sits at offset 0x10 and is read/write. `pins_out` equals it. A write changes `pins_out` on the clock edge that ends the write cycle.
- R4: A write to offset 0x18 sets every output-data bit written as one and leaves the zero bits unchanged.
- R5: A write to offset 0x20 clears every output-data bit written as one and leaves the zero bits unchanged.
- R6: Offset 0x08 returns the pin levels after two synchronizer flops, for all 32 pins whatever their direction. Writes to it are ignored. A read issued in a cycle (`reg_rd` high at an edge) presents its data on `reg_rdata` after that edge. In cycles without a read, `reg_rdata` is zero.
- R7: With mode bit n = 0 (n < 16), `irq_lines[n]` equals synchronized pin n XOR output-data bit n. Output-data 0 gives active-high/rising detection. Output-data 1 gives active-low/falling detection, presented as active-high.
- R8: With mode bit n = 1, `irq_lines[n]` is high for exactly one clock after each change of synchronized pin n, and output-data bit n has no effect on it.
- R9: The interrupt-mode register sits at offset 0x30. Bits 16 to 31 are not stored, read as zero and have no effect.
- R10: Reads of offsets 0x18, 0x20 and any unmapped offset return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_rd | input | 1 | Read strobe for the current cycle |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, zero when no read |
| pins_in | input | 32 | Asynchronous pin levels |
| pins_out | output | 32 | Pin output levels |
| pins_oe | output | 32 | Pin output enables |
| irq_lines | output | 16 | Per-pin interrupt lines for pins 0 to 15 |

## Verification
The bench targets the polarity inversion on a pin whose output bit is flipped while its level is held. A design that used the pin level without the XOR would leave the line stuck, and an active-low source would never be seen. It toggles pins in both-edge mode while also rewriting their output bits. A detector that still honoured polarity would hold the line high for more than one clock or miss falling edges. It also writes all-ones to the upper mode bits and to the input and unmapped offsets, and then reads them back. Leaking decode would corrupt the output register or return nonzero data. Set and clear writes that carry mixed bit patterns expose an alias that overwrites instead of merging.

// File: rtl/gpio_pol_irq_pkg.sv
package gpio_pol_irq_pkg;

    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_DIR  = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_IN   = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_OUT  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_SET  = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_CLR  = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_MODE = 8'h30;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_IN,
        SEL_OUT,
        SEL_SET,
        SEL_CLR,
        SEL_MODE,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] ofs);
        reg_sel_e s;
        unique case (ofs)
            OFS_DIR:  s = SEL_DIR;
            OFS_IN:   s = SEL_IN;
            OFS_OUT:  s = SEL_OUT;
            OFS_SET:  s = SEL_SET;
            OFS_CLR:  s = SEL_CLR;
            OFS_MODE: s = SEL_MODE;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    // warm-up counter so the latency check never looks back past reset
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && STAGES == 2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pol_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int NIRQ  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [BUS_AW-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  pin_lvl,
    output logic [NPINS-1:0]  rdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NIRQ-1:0]   mode_q
);

    reg_sel_e sel;
    assign sel = decode_ofs(addr);

    logic [NPINS-1:0] mode_wide;
    always_comb begin
        mode_wide = '0;
        mode_wide[NIRQ-1:0] = mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            mode_q <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_DIR:  dir_q  <= wdata;
                SEL_OUT:  out_q  <= wdata;
                SEL_SET:  out_q  <= out_q | wdata;
                SEL_CLR:  out_q  <= out_q & ~wdata;
                SEL_MODE: mode_q <= wdata[NIRQ-1:0];
                default:  ;
            endcase
        end
    end

    logic [NPINS-1:0] rd_mux;
    always_comb begin
        unique case (sel)
            SEL_DIR:  rd_mux = dir_q;
            SEL_IN:   rd_mux = pin_lvl;
            SEL_OUT:  rd_mux = out_q;
            SEL_MODE: rd_mux = mode_wide;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? rd_mux : '0;
    end

    // R4
    set_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R5
    clr_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_CLR) |=> ((out_q & $past(wdata)) == '0));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(out_q));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(out_q) && $stable(mode_q)));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> (rdata == '0));

    // R6
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rdata == '0));

endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
    parameter int NIRQ = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] lvl,
    input  logic [NIRQ-1:0] pol,
    input  logic [NIRQ-1:0] mode,
    output logic [NIRQ-1:0] irq
);

    logic [NIRQ-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    genvar i;
    generate
        for (i = 0; i < NIRQ; i++) begin : g_line
            always_comb begin
                if (mode[i]) irq[i] = lvl[i] ^ prev_q[i];
                else         irq[i] = lvl[i] ^ pol[i];
            end

            // R8
            both_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[i] && $stable(lvl[i])) |-> !irq[i]);

            // R7
            level_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!mode[i] && $stable(mode[i]) && $stable(lvl[i]) && $stable(pol[i]))
                |-> $stable(irq[i]));
        end
    endgenerate

endmodule

// File: rtl/gpio_pol_irq.sv
module gpio_pol_irq
    import gpio_pol_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int NIRQ        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pins_in,
    output logic [NPINS-1:0]  pins_out,
    output logic [NPINS-1:0]  pins_oe,
    output logic [NIRQ-1:0]   irq_lines
);

    logic [NPINS-1:0] lvl_sync;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NIRQ-1:0]  mode_q;

    gpio_sync #(
        .WIDTH (NPINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_in),
        .sync_out(lvl_sync)
    );

    gpio_regfile #(
        .NPINS(NPINS),
        .NIRQ (NIRQ)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pin_lvl(lvl_sync),
        .rdata  (reg_rdata),
        .dir_q  (dir_q),
        .out_q  (out_q),
        .mode_q (mode_q)
    );

    gpio_irq_gen #(
        .NIRQ(NIRQ)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl_sync[NIRQ-1:0]),
        .pol  (out_q[NIRQ-1:0]),
        .mode (mode_q),
        .irq  (irq_lines)
    );

    assign pins_out = out_q;
    assign pins_oe  = dir_q;

    // R2
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DIR) |=> (pins_oe == $past(reg_wdata)));

    // R3
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_OUT) |=> (pins_out == $past(reg_wdata)));

endmodule

// File: tb/sim_gpio_pol_irq.sv
module sim_gpio_pol_irq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pins_in = '0;
    logic [31:0] pins_out;
    logic [31:0] pins_oe;
    logic [15:0] irq_lines;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pol_irq u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pins_in  (pins_in),
        .pins_out (pins_out),
        .pins_oe  (pins_oe),
        .irq_lines(irq_lines)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_dir, m_out, m_mode, m_rdata, m_s1, m_s2, m_prev;
    string       m_rd_tag, m_out_tag;
    int          hist_q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_irq();
        logic [31:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            if (m_mode[i]) r[i] = m_s2[i] != m_prev[i];
            else           r[i] = m_s2[i] ^ m_out[i];
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_mode = '0; m_rdata = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_rd_tag = "R1"; m_out_tag = "R1";
        end else begin
            if (reg_rd) begin
                case (reg_addr)
                    8'h00: begin m_rdata = m_dir;  m_rd_tag = "R2"; end
                    8'h08: begin m_rdata = m_s2;   m_rd_tag = "R6"; end
                    8'h10: begin m_rdata = m_out;  m_rd_tag = "R3"; end
                    8'h30: begin m_rdata = m_mode; m_rd_tag = "R9"; end
                    default: begin m_rdata = '0;   m_rd_tag = "R10"; end
                endcase
            end else begin
                m_rdata = '0;
                m_rd_tag = "R6";
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'h00: m_dir = reg_wdata;
                    8'h10: begin m_out = reg_wdata; m_out_tag = "R3"; end
                    8'h18: begin m_out = m_out | reg_wdata; m_out_tag = "R4"; end
                    8'h20: begin m_out = m_out & ~reg_wdata; m_out_tag = "R5"; end
                    8'h30: m_mode = reg_wdata & 32'h0000_FFFF;
                    default: m_out_tag = "R10";
                endcase
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pins_in;
            hist_q.push_back(int'(m_s2[0]));
            if (hist_q.size() > 4) void'(hist_q.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 oe", pins_oe, m_dir);
            chk({m_out_tag, " out"}, pins_out, m_out);
            chk({m_rd_tag, " rdata"}, reg_rdata, m_rdata);
            chk((m_mode[15:0] == 16'h0) ? "R7 irq" :
                (m_mode[15:0] == 16'hFFFF) ? "R8 irq" : "R7/R8 irq",
                {16'h0, irq_lines}, ref_irq());
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pins(logic [31:0] v);
        @(negedge clk);
        pins_in = v;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 200000, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports
        chk("R1 oe", pins_oe, 32'h0);
        chk("R1 out", pins_out, 32'h0);
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 irq", {16'h0, irq_lines}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R2 direction
        wr(8'h00, 32'hA5A5_00FF); rd(8'h00);
        // R3 output data
        wr(8'h10, 32'h1234_5678); rd(8'h10);
        // R4 set and R5 clear with mixed patterns
        wr(8'h18, 32'h0000_F00F); rd(8'h10);
        wr(8'h20, 32'h1200_0008); rd(8'h10);
        wr(8'h18, 32'h0);         rd(8'h10);
        wr(8'h20, 32'h0);         rd(8'h10);

        // R6 input sampling, independent of direction
        pins(32'hDEAD_BEEF); idle(3); rd(8'h08);
        pins(32'h0F0F_1234); rd(8'h08); idle(2); rd(8'h08);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08); rd(8'h10);

        // R7 level mode with both polarities
        wr(8'h10, 32'h0000_00F0);
        pins(32'h0000_0011); idle(4);
        pins(32'h0000_0000); idle(4);
        wr(8'h20, 32'h0000_00F0); idle(2);
        wr(8'h18, 32'h0000_0003); idle(2);

        // R9 upper mode bits; R8 both-edge on pins 4..7
        wr(8'h30, 32'hFFFF_00F0); rd(8'h30);
        pins(32'h0010_0050); idle(4);
        wr(8'h18, 32'h0000_00F0); idle(2);
        pins(32'h0000_0000); idle(4);
        pins(32'h00F0_00F0); pins(32'h0000_0000); pins(32'h0000_00A0); idle(4);
        wr(8'h30, 32'h0000_FFFF); rd(8'h30);
        pins(32'h0000_FFFF); idle(4); pins(32'h0); idle(4);
        wr(8'h30, 32'h0);

        // R10 unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h04); rd(8'h18); rd(8'h20); rd(8'h10); rd(8'h00); rd(8'h30);

        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            logic [7:0] ofs_tab [8];
            ofs_tab = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h20, 8'h30, 8'h04, 8'h3C};
            @(negedge clk);
            reg_wr    = ($urandom % 3) == 0;
            reg_rd    = ($urandom % 2) == 0;
            reg_addr  = ofs_tab[$urandom % 8];
            reg_wdata = $urandom;
            if (($urandom % 2) == 0) pins_in = $urandom;
        end
        idle(4);
        finish_run();
    end

endmodule